// File: doc/BRIEF.md
# Far Control-Transfer Privilege Checker

This block judges a far jump or far call that names a new code selector. It receives the descriptor fetched for that selector, and, when the descriptor turns out to be a call gate, the code descriptor that the gate points to. It also receives the current privilege level, the selector the instruction carried (whose two low bits are the requested privilege level) and the instruction's own offset. From these it decides one outcome: allowed, not-present fault, or general-protection fault. For an allowed transfer it also gives the new code selector, the entry offset, the new privilege level, and a flag that says the stack must be switched.

The block handles three kinds of target. A plain code segment can only be entered at the same privilege level. A conforming code segment can be entered from an equal or less privileged level, and the caller's privilege level is kept. A call gate has to pass a three-way privilege comparison. It then supplies its own destination selector and entry offset. Only a call through a gate can move to a more privileged level. The decision is combinational, and the result is registered one cycle after a valid request.

Descriptor bit positions used throughout: present is bit 47, privilege is bits 46:45, the system flag is bit 44 (1 = code/data, 0 = system), bit 43 marks code, and bit 42 marks conforming code. A call gate is a system descriptor whose bits 43:40 equal 4'hC. Its destination selector is in bits 31:16 and its entry offset is {bits 63:48, bits 15:0}.

Top module: `farx_gatekeeper`

## Requirements
- R1: out_valid is high exactly one cycle after req_valid is high, and when out_valid is high exactly one of allow, fault_np and fault_gp is high.
- R2: A target with bit 44 = 1 and bit 43 = 1 and bit 42 = 0 (non-conforming code) is allowed only when its privilege equals cur_cpl. On allow, new_cpl = cur_cpl, new_ofs = ofs_in and new_sel = {sel_in[15:2], cur_cpl}.
- R3: A conforming code target (bit 42 = 1) is allowed when its privilege is numerically less than or equal to cur_cpl, and new_cpl stays cur_cpl. A privilege greater than cur_cpl gives fault_gp.
- R4: A target with bit 44 = 1 and bit 43 = 0 (data), or with bit 44 = 0 and bits 43:40 other than 4'hC, gives fault_gp.
- R5: The instruction's offset is ignored for a gate transfer.
- R6: A gate transfer gives fault_gp unless max(RPL, cur_cpl) is less than or equal to the gate privilege, and the destination privilege is less than or equal to cur_cpl.
- R7: An allowed gate transfer uses new_ofs = {gate[63:48], gate[15:0]} and new_sel = {gate[31:18], new_cpl}.
- R8: A call through a gate to a non-conforming destination with privilege below cur_cpl gives new_cpl = destination privilege and stk_switch = 1. Every other allowed transfer gives stk_switch = 0.
- R9: A jump through a gate to a non-conforming destination whose privilege differs from cur_cpl gives fault_gp. A jump to a conforming destination keeps cur_cpl.
- R10: A cleared present bit on the target, the gate or the gate's destination gives fault_np. Checks are made in this order: target type and privilege, then target present; for a gate, gate privilege, then gate present, then destination type and privilege, then destination present. The first check that fails sets the outcome.
- R11: On any fault, new_sel = 0, new_ofs = 0, new_cpl = cur_cpl and stk_switch = 0.
- R12: A gate whose destination descriptor is not code (bit 44 = 0 or bit 43 = 0) gives fault_gp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A transfer request is present this cycle |
| is_call | input | 1 | 1 = call, 0 = jump |
| cur_cpl | input | 2 | Current privilege level |
| sel_in | input | 16 | Selector from the instruction; bits 1:0 are the requested level |
| ofs_in | input | 32 | Offset from the instruction |
| desc_a | input | 64 | Descriptor fetched for sel_in |
| desc_b | input | 64 | Destination code descriptor named by a gate |
| out_valid | output | 1 | Registered result is valid |
| allow | output | 1 | Transfer permitted |
| fault_np | output | 1 | Not-present fault |
| fault_gp | output | 1 | General-protection fault |
| new_sel | output | 16 | New code selector |
| new_ofs | output | 32 | Entry offset |
| new_cpl | output | 2 | Privilege level after the transfer |
| stk_switch | output | 1 | Stack must be switched |

## Verification
The hardest outcomes to reach are the ones deep in the check order. One is a not-present fault on a gate's destination, which needs a gate and a destination that pass every earlier privilege and type test. Another is a privilege-raising call, which needs a gate privilege at least as large as both RPL and CPL together with a lower destination privilege. Directed vectors build these exact descriptor pairs, including a jump and a call through the same gate. Random descriptor pairs are then drawn with mostly-present, code-typed destinations so that the later checks are reached often.

// File: rtl/farx_pkg.sv
package farx_pkg;
    localparam int DESC_W = 64;
    localparam int SEL_W  = 16;
    localparam int OFS_W  = 32;
    localparam int PL_W   = 2;
    localparam int HALF_OFS = OFS_W / 2;

    localparam int P_BIT    = 47;
    localparam int DPL_LO   = 45;
    localparam int S_BIT    = 44;
    localparam int CODE_BIT = 43;
    localparam int CONF_BIT = 42;
    localparam int TYPE_LO  = 40;
    localparam int GSEL_LO  = 16;
    localparam int GOFS_HI  = 48;

    localparam logic [3:0] CALL_GATE_TYPE = 4'hC;

    typedef logic [PL_W-1:0] pl_t;

    typedef struct packed {
        logic             present;
        pl_t              dpl;
        logic             is_seg;
        logic             is_code;
        logic             is_conf;
        logic [3:0]       sys_type;
        logic [SEL_W-1:0] gsel;
        logic [OFS_W-1:0] gofs;
    } desc_t;

    typedef struct packed {
        logic             allow;
        logic             np;
        logic             gp;
        logic [SEL_W-1:0] sel;
        logic [OFS_W-1:0] ofs;
        pl_t              cpl;
        logic             stk;
    } res_t;
endpackage

// File: rtl/farx_desc_decode.sv
module farx_desc_decode
    import farx_pkg::*;
(
    input  logic [DESC_W-1:0] desc_i,
    output desc_t             dec_o,
    output logic              spare_o
);
    always_comb begin
        dec_o.present  = desc_i[P_BIT];
        dec_o.dpl      = desc_i[DPL_LO +: PL_W];
        dec_o.is_seg   = desc_i[S_BIT];
        dec_o.is_code  = desc_i[CODE_BIT];
        dec_o.is_conf  = desc_i[CONF_BIT];
        dec_o.sys_type = desc_i[TYPE_LO +: 4];
        dec_o.gsel     = desc_i[GSEL_LO +: SEL_W];
        dec_o.gofs     = {desc_i[GOFS_HI +: HALF_OFS], desc_i[0 +: HALF_OFS]};
    end

    // reserved bits between the base fields and the access byte
    assign spare_o = ^desc_i[TYPE_LO-1:GSEL_LO+SEL_W];
endmodule

// File: rtl/farx_rules.sv
module farx_rules
    import farx_pkg::*;
#(
    parameter logic [3:0] GATE_TYPE = CALL_GATE_TYPE
) (
    input  desc_t            tgt_i,
    input  desc_t            dst_i,
    input  logic             is_call_i,
    input  pl_t              cpl_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [OFS_W-1:0] ofs_i,
    output res_t             res_o,
    output logic             spare_o
);
    pl_t  eff_pl;
    logic tgt_gate;
    logic dir_priv_ok;
    logic dst_priv_ok;
    logic jmp_ok;
    pl_t  gate_cpl;

    always_comb begin
        eff_pl      = (sel_i[PL_W-1:0] > cpl_i) ? sel_i[PL_W-1:0] : cpl_i;
        tgt_gate    = !tgt_i.is_seg && (tgt_i.sys_type == GATE_TYPE);
        dir_priv_ok = tgt_i.is_conf ? (tgt_i.dpl <= cpl_i) : (tgt_i.dpl == cpl_i);
        dst_priv_ok = dst_i.dpl <= cpl_i;
        jmp_ok      = is_call_i || dst_i.is_conf || (dst_i.dpl == cpl_i);
        gate_cpl    = (!dst_i.is_conf && (dst_i.dpl < cpl_i)) ? dst_i.dpl : cpl_i;
    end

    always_comb begin
        res_o = '0;
        res_o.cpl = cpl_i;
        if (tgt_i.is_seg) begin
            if (!tgt_i.is_code || !dir_priv_ok) begin
                res_o.gp = 1'b1;
            end else if (!tgt_i.present) begin
                res_o.np = 1'b1;
            end else begin
                res_o.allow = 1'b1;
                res_o.sel   = {sel_i[SEL_W-1:PL_W], cpl_i};
                res_o.ofs   = ofs_i;
            end
        end else if (!tgt_gate) begin
            res_o.gp = 1'b1;
        end else if (eff_pl > tgt_i.dpl) begin
            res_o.gp = 1'b1;
        end else if (!tgt_i.present) begin
            res_o.np = 1'b1;
        end else if (!dst_i.is_seg || !dst_i.is_code || !dst_priv_ok || !jmp_ok) begin
            res_o.gp = 1'b1;
        end else if (!dst_i.present) begin
            res_o.np = 1'b1;
        end else begin
            res_o.allow = 1'b1;
            res_o.cpl   = gate_cpl;
            res_o.stk   = (gate_cpl != cpl_i);
            res_o.sel   = {tgt_i.gsel[SEL_W-1:PL_W], gate_cpl};
            res_o.ofs   = tgt_i.gofs;
        end
    end

    assign spare_o = ^{dst_i.gsel, dst_i.gofs, dst_i.sys_type, tgt_i.gsel[PL_W-1:0]};
endmodule

// File: rtl/farx_gatekeeper.sv
module farx_gatekeeper
    import farx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              is_call,
    input  logic [1:0]        cur_cpl,
    input  logic [15:0]       sel_in,
    input  logic [31:0]       ofs_in,
    input  logic [63:0]       desc_a,
    input  logic [63:0]       desc_b,
    output logic              out_valid,
    output logic              allow,
    output logic              fault_np,
    output logic              fault_gp,
    output logic [15:0]       new_sel,
    output logic [31:0]       new_ofs,
    output logic [1:0]        new_cpl,
    output logic              stk_switch
);
    typedef struct packed {
        logic vld;
        res_t res;
    } stage_t;

    desc_t  dec_tgt;
    desc_t  dec_dst;
    res_t   verdict;
    logic   spare_tgt, spare_dst, spare_rules;
    stage_t stage_d, stage_q;

    farx_desc_decode u_dec_tgt (.desc_i(desc_a), .dec_o(dec_tgt), .spare_o(spare_tgt));
    farx_desc_decode u_dec_dst (.desc_i(desc_b), .dec_o(dec_dst), .spare_o(spare_dst));

    farx_rules u_rules (
        .tgt_i     (dec_tgt),
        .dst_i     (dec_dst),
        .is_call_i (is_call),
        .cpl_i     (cur_cpl),
        .sel_i     (sel_in),
        .ofs_i     (ofs_in),
        .res_o     (verdict),
        .spare_o   (spare_rules)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = req_valid;
        if (req_valid) begin
            stage_d.res = verdict;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    logic spare_all;
    assign spare_all = spare_tgt ^ spare_dst ^ spare_rules;

    assign out_valid  = stage_q.vld;
    assign allow      = stage_q.res.allow;
    assign fault_np   = stage_q.res.np;
    assign fault_gp   = stage_q.res.gp;
    assign new_sel    = stage_q.res.sel;
    assign new_ofs    = stage_q.res.ofs;
    assign new_cpl    = stage_q.res.cpl;
    assign stk_switch = stage_q.res.stk;
endmodule

// File: rtl/farx_checker.sv
module farx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  cur_cpl,
    input logic        out_valid,
    input logic        allow,
    input logic        fault_np,
    input logic        fault_gp,
    input logic [15:0] new_sel,
    input logic [31:0] new_ofs,
    input logic [1:0]  new_cpl,
    input logic        stk_switch
);
    // R1
    vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(req_valid));

    // R1
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({allow, fault_np, fault_gp}) == 1);

    // R8
    stk_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && stk_switch) |-> (allow && new_cpl < $past(cur_cpl)));

    // R11
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !allow) |-> (!stk_switch && new_cpl == $past(cur_cpl)
                                   && new_sel == 16'h0 && new_ofs == 32'h0));

    // R3
    cpl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && allow && !stk_switch) |-> new_cpl == $past(cur_cpl));

    // R7
    sel_rpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && allow) |-> new_sel[1:0] == new_cpl);
endmodule

bind farx_gatekeeper farx_checker u_chk (.*);

// File: tb/farx_gatekeeper_bench.sv
module farx_gatekeeper_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        is_call = 1'b0;
    logic [1:0]  cur_cpl = 2'd0;
    logic [15:0] sel_in = 16'h0;
    logic [31:0] ofs_in = 32'h0;
    logic [63:0] desc_a = 64'h0;
    logic [63:0] desc_b = 64'h0;
    logic        out_valid, allow, fault_np, fault_gp, stk_switch;
    logic [15:0] new_sel;
    logic [31:0] new_ofs;
    logic [1:0]  new_cpl;

    farx_gatekeeper u_farx_gatekeeper (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        vld;
        logic        allow, np, gp;
        logic [15:0] sel;
        logic [31:0] ofs;
        logic [1:0]  cpl;
        logic        stk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad = 0;
    bit    finished = 0;

    function automatic logic [63:0] mk_code(bit p, int dpl, bit conf);
        return {8'h00, 4'h4, 4'hF, p, 2'(dpl), 1'b1, 1'b1, conf, 1'b1, 1'b0, 24'h0, 16'hFFFF};
    endfunction
    function automatic logic [63:0] mk_data(bit p, int dpl);
        return {8'h00, 4'h4, 4'hF, p, 2'(dpl), 1'b1, 3'b001, 1'b0, 24'h0, 16'hFFFF};
    endfunction
    function automatic logic [63:0] mk_sys(bit p, int dpl, logic [3:0] ty,
                                           logic [15:0] s, logic [31:0] o);
        return {o[31:16], p, 2'(dpl), 1'b0, ty, 8'h00, s, o[15:0]};
    endfunction

    // behavioural reference of the requirements
    task automatic model(output exp_t e, output string tag);
        int cpl = cur_cpl;
        int rpl = sel_in[1:0];
        int m, adpl, bdpl, ncpl;
        e = '0;
        e.vld = 1'b1;
        e.cpl = cur_cpl;
        adpl = desc_a[46:45];
        bdpl = desc_b[46:45];
        if (desc_a[44]) begin
            if (!desc_a[43]) begin e.gp = 1; tag = "R4"; end
            else if (desc_a[42] ? (adpl > cpl) : (adpl != cpl)) begin
                e.gp = 1; tag = desc_a[42] ? "R3" : "R2";
            end else if (!desc_a[47]) begin e.np = 1; tag = "R10"; end
            else begin
                e.allow = 1; e.sel = {sel_in[15:2], cur_cpl}; e.ofs = ofs_in;
                tag = desc_a[42] ? "R3" : "R2";
            end
        end else if (desc_a[43:40] != 4'hC) begin
            e.gp = 1; tag = "R4";
        end else begin
            m = (rpl > cpl) ? rpl : cpl;
            if (m > adpl) begin e.gp = 1; tag = "R6"; end
            else if (!desc_a[47]) begin e.np = 1; tag = "R10"; end
            else if (!desc_b[44] || !desc_b[43]) begin e.gp = 1; tag = "R12"; end
            else if (bdpl > cpl) begin e.gp = 1; tag = "R6"; end
            else if (!is_call && !desc_b[42] && bdpl != cpl) begin e.gp = 1; tag = "R9"; end
            else if (!desc_b[47]) begin e.np = 1; tag = "R10"; end
            else begin
                ncpl = (!desc_b[42] && bdpl < cpl) ? bdpl : cpl;
                e.allow = 1;
                e.cpl = 2'(ncpl);
                e.stk = (ncpl != cpl);
                e.sel = {desc_a[31:18], 2'(ncpl)};
                e.ofs = {desc_a[63:48], desc_a[15:0]};
                tag = e.stk ? "R8" : "R7";
            end
        end
        if (!e.allow && tag != "R10") tag = {tag, "/R11"};
    endtask

    task automatic compare_out();
        exp_t  e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (!e.vld) begin
            if (out_valid !== 1'b0) begin
                bad++;
                $display("FAIL R1 idle: out_valid=%b expected 0", out_valid);
            end
        end else if ({out_valid, allow, fault_np, fault_gp, new_sel, new_ofs, new_cpl, stk_switch} !== e) begin
            bad++;
            $display("FAIL %s: got v=%b a=%b np=%b gp=%b sel=%h ofs=%h cpl=%0d stk=%b expected v=%b a=%b np=%b gp=%b sel=%h ofs=%h cpl=%0d stk=%b",
                     t, out_valid, allow, fault_np, fault_gp, new_sel, new_ofs, new_cpl, stk_switch,
                     e.vld, e.allow, e.np, e.gp, e.sel, e.ofs, e.cpl, e.stk);
        end
    endtask

    // called at a falling edge: check the previous request, then drive a new one
    task automatic step(bit v, bit call, int cpl, logic [15:0] s, logic [31:0] o,
                        logic [63:0] a, logic [63:0] b);
        exp_t  e;
        string t;
        compare_out();
        req_valid = v; is_call = call; cur_cpl = 2'(cpl);
        sel_in = s; ofs_in = o; desc_a = a; desc_b = b;
        if (v) model(e, t);
        else begin e = '0; t = "R1"; end
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        logic [63:0] a, b;
        repeat (3) @(negedge clk);
        // R1 reset state
        total++;
        if (out_valid !== 1'b0 || allow !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: out_valid=%b allow=%b expected 0 0", out_valid, allow);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R2 direct same level / lower level
        step(1, 0, 2, 16'h1232, 32'hDEAD_0001, mk_code(1, 2, 0), 64'h0);
        step(1, 1, 2, 16'h1230, 32'h0000_0010, mk_code(1, 1, 0), 64'h0);
        // R3 conforming
        step(1, 1, 3, 16'h0043, 32'h0000_0400, mk_code(1, 0, 1), 64'h0);
        step(1, 0, 1, 16'h0041, 32'h0000_0400, mk_code(1, 3, 1), 64'h0);
        // R4 data and non-gate system
        step(1, 0, 0, 16'h0008, 32'h1, mk_data(1, 0), 64'h0);
        step(1, 1, 0, 16'h0008, 32'h1, mk_sys(1, 0, 4'h2, 16'h0010, 32'h5), 64'h0);
        step(0, 0, 0, 16'h0, 32'h0, 64'h0, 64'h0);
        // R8 / R5 privilege-raising call; instruction offset must be ignored
        a = mk_sys(1, 3, 4'hC, 16'h00A8, 32'h1234_5678);
        step(1, 1, 3, 16'h0033, 32'hFFFF_FFFF, a, mk_code(1, 0, 0));
        // R9 same gate as a jump
        step(1, 0, 3, 16'h0033, 32'hFFFF_FFFF, a, mk_code(1, 0, 0));
        // R6 gate privilege too high for caller, and RPL above gate
        step(1, 1, 3, 16'h0033, 32'h0, mk_sys(1, 1, 4'hC, 16'h0010, 32'h9), mk_code(1, 0, 0));
        step(1, 1, 1, 16'h0033, 32'h0, mk_sys(1, 2, 4'hC, 16'h0010, 32'h9), mk_code(1, 0, 0));
        // R10 not present gate, destination, direct
        step(1, 1, 3, 16'h0033, 32'h0, mk_sys(0, 3, 4'hC, 16'h0010, 32'h9), mk_code(1, 0, 0));
        step(1, 1, 3, 16'h0033, 32'h0, mk_sys(1, 3, 4'hC, 16'h0010, 32'h9), mk_code(0, 0, 0));
        step(1, 0, 2, 16'h0022, 32'h0, mk_code(0, 2, 0), 64'h0);
        // R12 gate to data
        step(1, 1, 3, 16'h0033, 32'h0, mk_sys(1, 3, 4'hC, 16'h0010, 32'h9), mk_data(1, 0));
        // R9 jump through gate to conforming keeps level
        step(1, 0, 2, 16'h0022, 32'h0, mk_sys(1, 3, 4'hC, 16'h0058, 32'hABCD_0004), mk_code(1, 0, 1));
        // R6 destination less privileged than caller
        step(1, 1, 1, 16'h0021, 32'h0, mk_sys(1, 3, 4'hC, 16'h0058, 32'h4), mk_code(1, 2, 0));
        // R7 call at same level
        step(1, 1, 2, 16'h0022, 32'h7, mk_sys(1, 2, 4'hC, 16'h0061, 32'h0BAD_F00D), mk_code(1, 2, 0));
        // random mix
        for (int i = 0; i < 1500; i++) begin
            int k = $urandom % 5;
            bit p1 = ($urandom % 8) != 0;
            bit p2 = ($urandom % 8) != 0;
            case (k)
                0: a = mk_code(p1, $urandom % 4, $urandom % 2);
                1: a = mk_data(p1, $urandom % 4);
                2, 3: a = mk_sys(p1, $urandom % 4, 4'hC, 16'($urandom), $urandom);
                default: a = {$urandom, $urandom};
            endcase
            b = (($urandom % 6) == 0) ? mk_data(p2, $urandom % 4)
                                      : mk_code(p2, $urandom % 4, $urandom % 2);
            step(($urandom % 8) != 0, $urandom % 2, $urandom % 4, 16'($urandom),
                 $urandom, a, b);
        end
        step(0, 0, 0, 16'h0, 32'h0, 64'h0, 64'h0);
        compare_out();
        summary();
    end
endmodule